// File: doc/BRIEF.md
# JTAG Master Shift Engine

This block is a clocked JTAG host controller. It drives TCK, TMS, TDI and the active-low test reset, and it samples TDO. A client issues high-level commands over a valid/ready handshake. The commands are: put the chain into reset, release the test reset, run idle cycles, enter the instruction or data shift path, shift a word of up to 32 bits, commit a pending shift, and two combined commands. Each combined command enters a path, shifts, and commits.

The engine does not model the TAP state graph. Its state has four values: reset, committed, running and shifting-data. Before the engine enters a new path or runs idle cycles, it checks this state. If a shift is still pending (the state is shifting-data), it first clocks two TMS-high pulses to commit. The engine builds every TCK pulse from three equal waits, each set by a half-period divider input. All data moves least significant bit first. When a command finishes, a one-cycle done pulse returns the TDO word captured during the shift.

Top module: `jtm_engine`

## Requirements
- R1: While the block is held in reset and right after reset, TCK is 0, TMS is 1, TDI is 1, trst_n is 0, cmd_ready is 1 and done is 0. The tracked state starts as reset.
- R2: Opcode 0 (chain reset) drives trst_n low and TDI high. It then clocks 7 TCK pulses with TMS 1,1,1,1,1,0,0, with no commit before them. The tracked state becomes reset.
- R3: Opcode 1 (release) drives trst_n high and produces no TCK pulse.
- R4: Each TCK pulse has three waits of half_period+1 clock cycles each: low, high, then low. TMS and TDI change only while TCK is low. TDO is sampled as TCK rises. TCK is low whenever the block is idle.
- R5: Opcode 6 (commit) clocks two pulses with TMS 1,1 and sets the state to committed, but only when the state is shifting-data. In any other state it clocks nothing.
- R6: Opcode 2 (run) first commits if the state is shifting-data. It then clocks cmd_count pulses with TMS 0 and sets the state to running. A count of 0 clocks only the commit.
- R7: Opcode 3 (enter data path) commits if needed, then clocks TMS 1,0. Opcode 4 (enter instruction path) commits if needed, then clocks TMS 1,1,0. Both set the state to shifting-data.
- R8: Opcode 5 (shift) clocks cmd_count pulses (1 to 32) with TMS 0. On pulse b, bit b of cmd_data is on TDI at the rising edge, and the TDO sample at that edge lands in bit b of rdata. Bits of rdata at and above cmd_count are 0.
- R9: Opcode 7 performs enter data path, then shift, then a two-pulse TMS-high commit. Opcode 8 does the same through the instruction path.
- R10: cmd_ready is high only while the block is idle, and a command is taken when cmd_valid and cmd_ready are both high. done pulses for exactly one cycle when a command completes, with rdata holding the captured word, or 0 for a command without a shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| half_period | input | DIV_W | Each TCK wait lasts half_period+1 cycles |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine idle, command can be taken |
| cmd_op | input | 4 | Opcode |
| cmd_count | input | CNT_W | Bit count or idle-cycle count |
| cmd_data | input | WORD_W | Word shifted out on TDI |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | WORD_W | Captured TDO word |
| tck | output | 1 | Test clock |
| tms | output | 1 | Test mode select |
| tdi | output | 1 | Test data to the chain |
| trst_n | output | 1 | Test reset, active low |
| tdo | input | 1 | Test data from the chain |

## Verification
The bench logs TMS and TDI at every TCK rise and compares each command's TMS pattern and pulse count with the expected values. This exposes a design that commits from a state other than shifting-data: it would add two stray TMS-high pulses, most visibly before entering a path after a run. The opposite fault, skipping the commit, leaves the data path entered straight from a pending shift, so the four-pulse 1,1,1,0 pattern would be missing. The bench returns TDO from its own pattern indexed by TCK rise count, so a capture that is off by one pulse or reversed in bit order changes rdata. The 32-bit shift, a count of one, a run of zero and a wider half period cover the boundaries of the counters and of the divider.

// File: rtl/jtm_pkg.sv
package jtm_pkg;

  typedef enum logic [3:0] {
    OP_RESET    = 4'd0,
    OP_RELEASE  = 4'd1,
    OP_RUN      = 4'd2,
    OP_ENTER_DR = 4'd3,
    OP_ENTER_IR = 4'd4,
    OP_SHIFT    = 4'd5,
    OP_COMMIT   = 4'd6,
    OP_DR_OUT   = 4'd7,
    OP_IR_OUT   = 4'd8
  } jtm_op_e;

  // abstract position of the chain
  typedef enum logic [1:0] {
    PS_RST    = 2'd0,
    PS_COMMIT = 2'd1,
    PS_RUN    = 2'd2,
    PS_DATA   = 2'd3
  } jtm_path_e;

  // command expansion steps, walked in order
  typedef enum logic [2:0] {
    ST_PRE   = 3'd0,
    ST_MAIN  = 3'd1,
    ST_SHIFT = 3'd2,
    ST_POST  = 3'd3,
    ST_FIN   = 3'd4
  } jtm_step_e;

  // three waits of one TCK pulse
  typedef enum logic [1:0] {
    PH_LEAD  = 2'd0,
    PH_HIGH  = 2'd1,
    PH_TRAIL = 2'd2
  } jtm_phase_e;

endpackage

// File: rtl/jtm_bitclk.sv
module jtm_bitclk
  import jtm_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int CNT_W  = 6,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  half_i,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  nbits_i,
  input  logic [WORD_W-1:0] tms_word_i,
  input  logic [WORD_W-1:0] tdi_word_i,
  input  logic              drive_tdi_i,
  input  logic              tdo_i,
  output logic              busy_o,
  output logic              fin_o,
  output logic [WORD_W-1:0] cap_o,
  output logic              tck_o,
  output logic              tms_o,
  output logic              tdi_o
);

  localparam int IDX_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
  localparam logic [CNT_W:0] WORD_LIM = (CNT_W+1)'(WORD_W);

  logic              act_q, act_d;
  jtm_phase_e        ph_q, ph_d;
  logic [DIV_W-1:0]  div_q, div_d;
  logic [CNT_W-1:0]  idx_q, idx_d, n_q, n_d, idx_nx;
  logic [WORD_W-1:0] tmsw_q, tmsw_d, tdiw_q, tdiw_d, cap_q, cap_d;
  logic              drv_q, drv_d, tck_q, tck_d, tms_q, tms_d, tdi_q, tdi_d;
  logic              fin_q, fin_d;

  function automatic logic bit_at(input logic [WORD_W-1:0] w, input logic [CNT_W-1:0] i);
    if ({1'b0, i} < WORD_LIM) return w[i[IDX_W-1:0]];
    return 1'b0;
  endfunction

  assign idx_nx = idx_q + CNT_W'(1);

  always_comb begin
    act_d  = act_q;  ph_d   = ph_q;   div_d = div_q;  idx_d = idx_q;
    n_d    = n_q;    tmsw_d = tmsw_q; tdiw_d = tdiw_q; drv_d = drv_q;
    cap_d  = cap_q;  tck_d  = tck_q;  tms_d = tms_q;  tdi_d = tdi_q;
    fin_d  = 1'b0;
    if (!act_q) begin
      if (start_i) begin
        act_d  = 1'b1;
        ph_d   = PH_LEAD;
        div_d  = '0;
        idx_d  = '0;
        n_d    = nbits_i;
        tmsw_d = tms_word_i;
        tdiw_d = tdi_word_i;
        drv_d  = drive_tdi_i;
        cap_d  = '0;
        tms_d  = tms_word_i[0];
        if (drive_tdi_i) tdi_d = tdi_word_i[0];
      end
    end else if (div_q != half_i) begin
      div_d = div_q + DIV_W'(1);
    end else begin
      div_d = '0;
      case (ph_q)
        PH_LEAD: begin
          ph_d  = PH_HIGH;
          tck_d = 1'b1;
          if ({1'b0, idx_q} < WORD_LIM) cap_d[idx_q[IDX_W-1:0]] = tdo_i;
        end
        PH_HIGH: begin
          ph_d  = PH_TRAIL;
          tck_d = 1'b0;
        end
        default: begin
          if (idx_q == n_q - CNT_W'(1)) begin
            act_d = 1'b0;
            fin_d = 1'b1;
          end else begin
            idx_d = idx_nx;
            ph_d  = PH_LEAD;
            tms_d = bit_at(tmsw_q, idx_nx);
            if (drv_q) tdi_d = bit_at(tdiw_q, idx_nx);
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0; ph_q <= PH_LEAD; div_q <= '0; idx_q <= '0; n_q <= '0;
      tmsw_q <= '0; tdiw_q <= '0; drv_q <= 1'b0; cap_q <= '0;
      tck_q <= 1'b0; tms_q <= 1'b1; tdi_q <= 1'b1; fin_q <= 1'b0;
    end else begin
      act_q <= act_d; ph_q <= ph_d; div_q <= div_d; idx_q <= idx_d; n_q <= n_d;
      tmsw_q <= tmsw_d; tdiw_q <= tdiw_d; drv_q <= drv_d; cap_q <= cap_d;
      tck_q <= tck_d; tms_q <= tms_d; tdi_q <= tdi_d; fin_q <= fin_d;
    end
  end

  assign busy_o = act_q;
  assign fin_o  = fin_q;
  assign cap_o  = cap_q;
  assign tck_o  = tck_q;
  assign tms_o  = tms_q;
  assign tdi_o  = tdi_q;

  AST_PINS_HOLD_WHILE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    $past(tck_q) |-> ($stable(tms_q) && $stable(tdi_q))); // R4
  AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |-> (!act_q && nbits_i != '0)); // R10

endmodule

// File: rtl/jtm_seq.sv
module jtm_seq
  import jtm_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int CNT_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [3:0]        cmd_op,
  input  logic [CNT_W-1:0]  cmd_count,
  input  logic [WORD_W-1:0] cmd_data,
  input  logic              eng_fin,
  input  logic [WORD_W-1:0] eng_cap,
  output logic              eng_start,
  output logic [CNT_W-1:0]  eng_nbits,
  output logic [WORD_W-1:0] eng_tms,
  output logic [WORD_W-1:0] eng_tdi,
  output logic              eng_drive,
  output logic              trst_n_o,
  output logic              done_o,
  output logic [WORD_W-1:0] rdata_o
);

  logic              busy_q, busy_d, wait_q, wait_d, trst_q, trst_d, done_q, done_d;
  jtm_step_e         step_q, step_d;
  jtm_op_e           op_q, op_d;
  jtm_path_e         path_q, path_d, upd_path;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [WORD_W-1:0] data_q, data_d, rdata_q, rdata_d;
  logic              seg_v, upd_v;

  function automatic jtm_step_e step_next(input jtm_step_e s);
    case (s)
      ST_PRE:   return ST_MAIN;
      ST_MAIN:  return ST_SHIFT;
      ST_SHIFT: return ST_POST;
      default:  return ST_FIN;
    endcase
  endfunction

  function automatic logic wants_commit(input jtm_op_e o);
    return (o == OP_RUN) || (o == OP_ENTER_DR) || (o == OP_ENTER_IR) ||
           (o == OP_COMMIT) || (o == OP_DR_OUT) || (o == OP_IR_OUT);
  endfunction

  // segment decode for the current step
  always_comb begin
    seg_v = 1'b0; eng_nbits = '0; eng_tms = '0; eng_tdi = '0; eng_drive = 1'b0;
    upd_v = 1'b0; upd_path = path_q;
    case (step_q)
      ST_PRE: if (wants_commit(op_q) && path_q == PS_DATA) begin
        seg_v = 1'b1; eng_nbits = CNT_W'(2); eng_tms = WORD_W'(2'b11);
        upd_v = 1'b1; upd_path = PS_COMMIT;
      end
      ST_MAIN: case (op_q)
        OP_RESET: begin
          seg_v = 1'b1; eng_nbits = CNT_W'(7); eng_tms = WORD_W'(5'h1F);
          eng_tdi = '1; eng_drive = 1'b1; upd_v = 1'b1; upd_path = PS_RST;
        end
        OP_RUN: begin
          seg_v = (cnt_q != '0); eng_nbits = cnt_q;
          upd_v = 1'b1; upd_path = PS_RUN;
        end
        OP_ENTER_DR, OP_DR_OUT: begin
          seg_v = 1'b1; eng_nbits = CNT_W'(2); eng_tms = WORD_W'(2'b01);
          upd_v = 1'b1; upd_path = PS_DATA;
        end
        OP_ENTER_IR, OP_IR_OUT: begin
          seg_v = 1'b1; eng_nbits = CNT_W'(3); eng_tms = WORD_W'(3'b011);
          upd_v = 1'b1; upd_path = PS_DATA;
        end
        default: ;
      endcase
      ST_SHIFT: if (op_q == OP_SHIFT || op_q == OP_DR_OUT || op_q == OP_IR_OUT) begin
        seg_v = (cnt_q != '0); eng_nbits = cnt_q; eng_tdi = data_q; eng_drive = 1'b1;
      end
      ST_POST: if (op_q == OP_DR_OUT || op_q == OP_IR_OUT) begin
        seg_v = 1'b1; eng_nbits = CNT_W'(2); eng_tms = WORD_W'(2'b11);
        upd_v = 1'b1; upd_path = PS_COMMIT;
      end
      default: ;
    endcase
  end

  always_comb begin
    busy_d = busy_q; wait_d = wait_q; trst_d = trst_q; done_d = 1'b0;
    step_d = step_q; op_d = op_q; path_d = path_q; cnt_d = cnt_q;
    data_d = data_q; rdata_d = rdata_q; eng_start = 1'b0;
    if (!busy_q) begin
      if (cmd_valid) begin
        busy_d  = 1'b1;
        wait_d  = 1'b0;
        step_d  = ST_PRE;
        op_d    = jtm_op_e'(cmd_op);
        cnt_d   = cmd_count;
        data_d  = cmd_data;
        rdata_d = '0;
        if (cmd_op == OP_RESET)   trst_d = 1'b0;
        if (cmd_op == OP_RELEASE) trst_d = 1'b1;
      end
    end else if (wait_q) begin
      if (eng_fin) begin
        wait_d = 1'b0;
        step_d = step_next(step_q);
        if (step_q == ST_SHIFT) rdata_d = eng_cap;
      end
    end else if (step_q == ST_FIN) begin
      busy_d = 1'b0;
      done_d = 1'b1;
    end else begin
      if (upd_v) path_d = upd_path;
      if (seg_v) begin
        eng_start = 1'b1;
        wait_d    = 1'b1;
      end else begin
        step_d = step_next(step_q);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0; wait_q <= 1'b0; trst_q <= 1'b0; done_q <= 1'b0;
      step_q <= ST_PRE; op_q <= OP_RESET; path_q <= PS_RST; cnt_q <= '0;
      data_q <= '0; rdata_q <= '0;
    end else begin
      busy_q <= busy_d; wait_q <= wait_d; trst_q <= trst_d; done_q <= done_d;
      step_q <= step_d; op_q <= op_d; path_q <= path_d; cnt_q <= cnt_d;
      data_q <= data_d; rdata_q <= rdata_d;
    end
  end

  assign cmd_ready = !busy_q;
  assign trst_n_o  = trst_q;
  assign done_o    = done_q;
  assign rdata_o   = rdata_q;

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R10
  AST_RESET_PULLS_TRST: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !busy_q && cmd_op == OP_RESET) |=> !trst_q); // R2
  AST_FIN_NOT_WHILE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    eng_fin |-> (busy_q && wait_q)); // R10

endmodule

// File: rtl/jtm_engine.sv
module jtm_engine
  import jtm_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int CNT_W  = 6,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  half_period,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [3:0]        cmd_op,
  input  logic [CNT_W-1:0]  cmd_count,
  input  logic [WORD_W-1:0] cmd_data,
  output logic              done,
  output logic [WORD_W-1:0] rdata,
  output logic              tck,
  output logic              tms,
  output logic              tdi,
  output logic              trst_n,
  input  logic              tdo
);

  logic [1:0]        rsync_q;
  logic              rst_s_n;
  logic              eng_start, eng_busy, eng_fin, eng_drive;
  logic [CNT_W-1:0]  eng_nbits;
  logic [WORD_W-1:0] eng_tms, eng_tdi, eng_cap;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_s_n = rsync_q[1];

  jtm_seq #(.WORD_W(WORD_W), .CNT_W(CNT_W)) seq_i (
    .clk(clk), .rst_n(rst_s_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_count(cmd_count), .cmd_data(cmd_data),
    .eng_fin(eng_fin), .eng_cap(eng_cap), .eng_start(eng_start),
    .eng_nbits(eng_nbits), .eng_tms(eng_tms), .eng_tdi(eng_tdi), .eng_drive(eng_drive),
    .trst_n_o(trst_n), .done_o(done), .rdata_o(rdata)
  );

  jtm_bitclk #(.WORD_W(WORD_W), .CNT_W(CNT_W), .DIV_W(DIV_W)) clk_i (
    .clk(clk), .rst_n(rst_s_n), .half_i(half_period),
    .start_i(eng_start), .nbits_i(eng_nbits), .tms_word_i(eng_tms),
    .tdi_word_i(eng_tdi), .drive_tdi_i(eng_drive), .tdo_i(tdo),
    .busy_o(eng_busy), .fin_o(eng_fin), .cap_o(eng_cap),
    .tck_o(tck), .tms_o(tms), .tdi_o(tdi)
  );

  AST_TCK_LOW_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_s_n)
    cmd_ready |-> !tck); // R4
  AST_ENGINE_ONLY_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_s_n)
    eng_busy |-> !cmd_ready); // R10

endmodule

// File: tb/jtm_engine_tb_top.sv
module jtm_engine_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] TDO_PAT = 32'hC3A5_96E1;

  typedef struct packed {
    logic [3:0]  op;
    logic [5:0]  cnt;
    logic [31:0] data;
    logic [7:0]  nr;
    logic [63:0] tmsx;
    logic [7:0]  pre;
    logic [1:0]  mode;  // 0 none, 1 shift data on TDI, 2 TDI all ones
  } vec_t;

  localparam int NVEC = 19;
  localparam vec_t VEC [0:NVEC-1] = '{
    '{4'd0, 6'd0,  32'h0,        8'd7,  64'h1F,  8'd0, 2'd2},
    '{4'd1, 6'd0,  32'h0,        8'd0,  64'h0,   8'd0, 2'd0},
    '{4'd2, 6'd5,  32'h0,        8'd5,  64'h0,   8'd0, 2'd0},
    '{4'd7, 6'd8,  32'hA5,       8'd12, 64'hC01, 8'd2, 2'd1},
    '{4'd4, 6'd0,  32'h0,        8'd3,  64'h3,   8'd0, 2'd0},
    '{4'd5, 6'd6,  32'h2A,       8'd6,  64'h0,   8'd0, 2'd1},
    '{4'd3, 6'd0,  32'h0,        8'd4,  64'h7,   8'd0, 2'd0},
    '{4'd5, 6'd32, 32'hDEADBEEF, 8'd32, 64'h0,   8'd0, 2'd1},
    '{4'd2, 6'd3,  32'h0,        8'd5,  64'h3,   8'd0, 2'd0},
    '{4'd6, 6'd0,  32'h0,        8'd0,  64'h0,   8'd0, 2'd0},
    '{4'd8, 6'd6,  32'h3F,       8'd11, 64'h603, 8'd3, 2'd1},
    '{4'd2, 6'd0,  32'h0,        8'd0,  64'h0,   8'd0, 2'd0},
    '{4'd3, 6'd0,  32'h0,        8'd2,  64'h1,   8'd0, 2'd0},
    '{4'd6, 6'd0,  32'h0,        8'd2,  64'h3,   8'd0, 2'd0},
    '{4'd3, 6'd0,  32'h0,        8'd2,  64'h1,   8'd0, 2'd0},
    '{4'd0, 6'd0,  32'h0,        8'd7,  64'h1F,  8'd0, 2'd2},
    '{4'd1, 6'd0,  32'h0,        8'd0,  64'h0,   8'd0, 2'd0},
    '{4'd7, 6'd1,  32'h1,        8'd5,  64'h19,  8'd2, 2'd1},
    '{4'd5, 6'd4,  32'h9,        8'd4,  64'h0,   8'd0, 2'd1}
  };

  logic        clk, rst_n, cmd_valid, cmd_ready, done, tck, tms, tdi, trst_n, tdo;
  logic [7:0]  half_period;
  logic [3:0]  cmd_op;
  logic [5:0]  cmd_count;
  logic [31:0] cmd_data, rdata;

  int checks = 0, failures = 0, rise_cnt = 0, hi_cnt = 0;
  logic tms_log [0:255];
  logic tdi_log [0:255];
  bit   finished = 0;

  jtm_engine dut_i (
    .clk(clk), .rst_n(rst_n), .half_period(half_period),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_count(cmd_count), .cmd_data(cmd_data), .done(done), .rdata(rdata),
    .tck(tck), .tms(tms), .tdi(tdi), .trst_n(trst_n), .tdo(tdo)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  assign tdo = TDO_PAT[rise_cnt % 32];

  always @(posedge tck) begin
    tms_log[rise_cnt % 256] = tms;
    tdi_log[rise_cnt % 256] = tdi;
    rise_cnt = rise_cnt + 1;
  end

  always @(negedge clk) if (tck === 1'b1) hi_cnt = hi_cnt + 1;

  function automatic string tag_of(input logic [3:0] op);
    case (op)
      4'd0: return "R2";
      4'd1: return "R3";
      4'd2: return "R6";
      4'd3, 4'd4: return "R7";
      4'd5: return "R8";
      4'd6: return "R5";
      default: return "R9";
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic do_cmd(input logic [3:0] op, input logic [5:0] cnt, input logic [31:0] data,
                        output logic [31:0] rd, output int start, output int nrise);
    int guard;
    start = rise_cnt;
    cmd_op = op; cmd_count = cnt; cmd_data = data; cmd_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(cmd_ready == 1'b0, "R10", "ready low while busy", 64'(cmd_ready), 64'd0);
    guard = 0;
    while (done !== 1'b1 && guard < 20000) begin
      @(negedge clk);
      guard++;
    end
    rd = rdata;
    nrise = rise_cnt - start;
    @(negedge clk);
    chk(done == 1'b0, "R10", "done single cycle", 64'(done), 64'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired: actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd, exp_rd;
    logic [63:0] act_tms, act_tdi, exp_tdi;
    int st, nr, h0;
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = '0; cmd_count = '0; cmd_data = '0;
    half_period = 8'd1;
    repeat (3) @(negedge clk);
    // R1 values held in reset
    chk(tck == 1'b0 && tms == 1'b1 && tdi == 1'b1, "R1", "pins in reset",
        {61'd0, tck, tms, tdi}, 64'h3);
    chk(trst_n == 1'b0 && cmd_ready == 1'b1 && done == 1'b0, "R1", "control in reset",
        {61'd0, trst_n, cmd_ready, done}, 64'h2);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(cmd_ready == 1'b1 && tck == 1'b0 && trst_n == 1'b0, "R1", "after reset release",
        {61'd0, cmd_ready, tck, trst_n}, 64'h4);

    for (int v = 0; v < NVEC; v++) begin
      do_cmd(VEC[v].op, VEC[v].cnt, VEC[v].data, rd, st, nr);
      chk(nr == int'(VEC[v].nr), tag_of(VEC[v].op), $sformatf("pulse count vec %0d", v),
          64'(nr), 64'(VEC[v].nr));
      act_tms = '0; act_tdi = '0; exp_tdi = '0; exp_rd = '0;
      for (int i = 0; i < nr && i < 64; i++) act_tms[i] = tms_log[(st + i) % 256];
      chk(act_tms == VEC[v].tmsx, tag_of(VEC[v].op), $sformatf("TMS pattern vec %0d", v),
          act_tms, VEC[v].tmsx);
      if (VEC[v].mode == 2'd1) begin
        for (int b = 0; b < int'(VEC[v].cnt); b++) begin
          act_tdi[b] = tdi_log[(st + int'(VEC[v].pre) + b) % 256];
          exp_rd[b]  = TDO_PAT[(st + int'(VEC[v].pre) + b) % 32];
        end
        exp_tdi = 64'(VEC[v].data) & ((64'd1 << VEC[v].cnt) - 64'd1);
        chk(act_tdi == exp_tdi, "R8", $sformatf("TDI bits vec %0d", v), act_tdi, exp_tdi);
      end else if (VEC[v].mode == 2'd2) begin
        for (int i = 0; i < nr && i < 64; i++) act_tdi[i] = tdi_log[(st + i) % 256];
        exp_tdi = (64'd1 << VEC[v].nr) - 64'd1;
        chk(act_tdi == exp_tdi, "R2", $sformatf("TDI high vec %0d", v), act_tdi, exp_tdi);
      end
      chk(rd == exp_rd, tag_of(VEC[v].op), $sformatf("rdata vec %0d", v),
          64'(rd), 64'(exp_rd));
      if (VEC[v].op == 4'd0)
        chk(trst_n == 1'b0, "R2", "trst low after reset cmd", 64'(trst_n), 64'd0);
      if (VEC[v].op == 4'd1)
        chk(trst_n == 1'b1, "R3", "trst high after release", 64'(trst_n), 64'd1);
    end

    // R4 wider divider: one run pulse with half_period 2 stays high 3 cycles
    half_period = 8'd2;
    h0 = hi_cnt;
    do_cmd(4'd2, 6'd1, 32'h0, rd, st, nr);
    chk(hi_cnt - h0 == 3, "R4", "TCK high width", 64'(hi_cnt - h0), 64'd3);
    chk(nr == 1, "R6", "single run pulse", 64'(nr), 64'd1);
    chk(tck == 1'b0, "R4", "TCK low when idle", 64'(tck), 64'd0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule